// File: doc/BRIEF.md
# Auto-Reload Wakeup Timer

This block is a periodic wakeup source. A down-counter is loaded from a programmable reload value and steps once per tick. When it is at zero on a tick, it reloads and sets an event flag. The tick comes from one of two kinds of source. The first is the block clock divided by 16, 8, 4 or 2, taken from an internal prescaler that restarts each time the timer is started. The second is an externally supplied one-per-second strobe, which can be used either plainly or with 2^16 added to the reload value, so that the period can exceed 18 hours.

Software drives the block through a small register port with a write strobe, an address and data. A control word holds the run enable, the interrupt enable and the tick source. A reload register holds the count. A status word carries the event flag, which is cleared by writing 1, and a write-allowed bit. The reload register accepts writes only while write-allowed reads 1, which is the case only while the timer is fully stopped. The interrupt line is the event flag gated by the interrupt enable.

The sequencing is a four-state machine:
- **IDLE**: the counter is stopped and the reload register is writable.
- **LOAD**: entered from IDLE when the enable is seen. The counter is loaded and the prescaler is cleared.
- **COUNT**: entered from LOAD while the enable holds. Ticks are counted here.
- **DRAIN**: entered from LOAD or COUNT when the enable drops. It lasts one cycle and always returns to IDLE.

Top module: `wakeup_reload_timer`

## Requirements
- R1: After reset, the register reads are as follows: address 0 (control) reads 0, address 1 (reload) reads 0xFFFF, and address 2 (status) reads 0x0002. In the status word, bit 0 is the event flag and bit 1 is write-allowed. Both wake_flag and wake_irq are low. The control word layout is: bit 0 run enable, bit 1 interrupt enable, bits 6:4 tick source.
- R2: For tick sources 0, 1, 2 and 3 (clock divided by 16, 8, 4 and 2 respectively) with reload value R, suppose the enable write is sampled at clock edge c. The first rise of wake_flag then occurs at edge c + 2 + N*(R+1).
- R3: Tick sources 4 and 5 count one tick for each clock cycle in which sec_tick is high while running. No count happens without the strobe. With reload R, the flag rises on the (R+1)-th strobe.
- R4: Tick sources 6 and 7 count sec_tick strobes and add 65536 to the reload value. The flag rises on strobe R+65537.
- R5: The counter reloads on reaching zero and keeps running, whatever the state of the flag. Successive flag events are N*(R+1) cycles apart.
- R6: A write to the reload register (address 1) takes effect only while write-allowed is 1. At any other time it is ignored, and the old value reads back.
- R7: Write-allowed reads 0 from the edge after an enable-setting write. After the enable is cleared, it reads 0 one cycle later and 1 two cycles later.
- R8: Writing status with bit 0 set clears the flag. Writing 0 there has no effect. A set and a clear at the same edge leave the flag set.
- R9: wake_irq is high exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divided tick base |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-per-second strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| write_ok | output | 1 | Reload register may be written |
| wake_flag | output | 1 | Event flag |
| wake_irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is an event set landing on the very edge where a clear write is sampled. The bench reaches it with the fastest source and a zero reload, so the timer sets the flag on every second edge. It then starts the clear write on a cycle it has counted from the enable edge. The second is the extended strobe range. The bench holds sec_tick high so that every running cycle is a tick, which brings the 65539-tick period within reach. A scoreboard then checks the exact edge of the rise.

// File: rtl/wrt_pkg.sv
package wrt_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_DRAIN = 2'd3
    } wrt_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    localparam int B_EN  = 0;
    localparam int B_IE  = 1;
    localparam int B_SRC = 4;
endpackage

// File: rtl/wrt_tick_gen.sv
module wrt_tick_gen #(
    parameter int PRE_W = wrt_pkg::PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       sec_tick,
    input  logic [2:0] src,
    output logic       tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    // source 0 -> all ones (/16), each step halves the period
    always_comb mask = {PRE_W{1'b1}} >> src[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (run)     div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (src[2]) tick = run && sec_tick;
        else        tick = run && ((div_q & mask) == mask);
    end

    assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src[2] && !sec_tick) |-> !tick);
endmodule

// File: rtl/wrt_ctrl_fsm.sv
module wrt_ctrl_fsm
    import wrt_pkg::*;
#(
    parameter int CNT_W = wrt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             extend,
    output logic             run,
    output logic             restart,
    output logic             write_ok,
    output logic             wrap
);
    localparam int FULL_W = CNT_W + 1;

    wrt_state_e        state_q, state_d;
    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] full;

    always_comb full = {extend, reload_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable) state_d = ST_LOAD;
            ST_LOAD:  state_d = enable ? ST_COUNT : ST_DRAIN;
            ST_COUNT: if (!enable) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run      = 1'b0;
        restart  = 1'b0;
        write_ok = 1'b0;
        unique case (state_q)
            ST_IDLE:  write_ok = !enable;
            ST_LOAD:  restart  = 1'b1;
            ST_COUNT: run      = 1'b1;
            ST_DRAIN: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart)          cnt_q <= full;
        else if (tick) begin
            if (cnt_q == '0)       cnt_q <= full;
            else                   cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb wrap = tick && (cnt_q == '0);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !restart) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0) |=> (cnt_q == $past(full)));
    assert_wok_rise_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_ok) |-> !enable && !run);
endmodule

// File: rtl/wrt_regs.sv
module wrt_regs
    import wrt_pkg::*;
#(
    parameter int CNT_W  = wrt_pkg::CNT_W,
    parameter int ADDR_W = wrt_pkg::ADDR_W,
    parameter int DATA_W = wrt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              write_ok,
    input  logic              wrap,
    output logic              enable,
    output logic              irq_en,
    output logic [2:0]        src,
    output logic [CNT_W-1:0]  reload_q,
    output logic              flag,
    output logic              irq
);
    logic wr_ctrl, wr_reload, clr_req;

    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_reload = wr_en && (wr_addr == A_RELOAD) && write_ok;
        clr_req   = wr_en && (wr_addr == A_STATUS) && wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            irq_en <= 1'b0;
            src    <= '0;
        end else if (wr_ctrl) begin
            enable <= wr_data[B_EN];
            irq_en <= wr_data[B_IE];
            src    <= wr_data[B_SRC +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         reload_q <= '1;
        else if (wr_reload) reload_q <= wr_data[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (wrap)    flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    always_comb irq = flag & irq_en;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data = DATA_W'({src, 2'b00, irq_en, enable});
            A_RELOAD: rd_data = DATA_W'(reload_q);
            A_STATUS: rd_data = DATA_W'({write_ok, flag});
            default:  rd_data = '0;
        endcase
    end

    assert_reload_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !write_ok |=> $stable(reload_q));
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !wrap) |=> !flag);
endmodule

// File: rtl/wakeup_reload_timer.sv
module wakeup_reload_timer
    import wrt_pkg::*;
#(
    parameter int CNT_W  = wrt_pkg::CNT_W,
    parameter int PRE_W  = wrt_pkg::PRE_W,
    parameter int ADDR_W = wrt_pkg::ADDR_W,
    parameter int DATA_W = wrt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              write_ok,
    output logic              wake_flag,
    output logic              wake_irq
);
    logic             enable, irq_en, run, restart, tick, wrap;
    logic [2:0]       src;
    logic [CNT_W-1:0] reload_q;

    wrt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .write_ok(write_ok), .wrap(wrap), .enable(enable), .irq_en(irq_en),
        .src(src), .reload_q(reload_q), .flag(wake_flag), .irq(wake_irq)
    );

    wrt_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .sec_tick(sec_tick), .src(src), .tick(tick)
    );

    // sources 6 and 7 extend the reload by one extra top bit
    wrt_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .reload_val(reload_q), .extend(src[2] & src[1]), .run(run),
        .restart(restart), .write_ok(write_ok), .wrap(wrap)
    );

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq |-> wake_flag) and (!wake_flag |-> !wake_irq));
endmodule

// File: tb/wakeup_reload_timer_bench.sv
module wakeup_reload_timer_bench;
    import wrt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        write_ok, wake_flag, wake_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit sb_on  = 1'b0;
    bit done   = 1'b0;
    logic prev_flag = 1'b0;

    typedef struct { int at; string req; } exp_t;
    exp_t exp_q[$];

    wakeup_reload_timer u_wakeup_reload_timer (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .write_ok(write_ok), .wake_flag(wake_flag),
        .wake_irq(wake_irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int c0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        c0 = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic wait_flag();
        while (!wake_flag) @(negedge clk);
    endtask

    task automatic stop_timer(input logic [15:0] ctrl);
        int c;
        wr(A_CTRL, ctrl & 16'hFFFE, c);
        while (!write_ok) @(negedge clk);
        wr(A_STATUS, 16'h0001, c);
    endtask

    // scoreboard monitor: every flag rise must match the next expected edge
    always @(negedge clk) begin
        if (sb_on && rst_n && wake_flag && !prev_flag) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected flag rise: actual cycle %0d expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at != cyc) begin
                    fails++;
                    $display("FAIL %s: flag rose at actual %0d expected %0d", e.req, cyc, e.at);
                end
            end
        end
        prev_flag <= wake_flag;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int c, v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_RELOAD, v); chk("R1 reload", v, 16'hFFFF);
        rd(A_STATUS, v); chk("R1 status", v, 2);
        chk("R1 irq", int'(wake_irq), 0);

        // divide by 2, reload 3, irq on: R2, R5, R6, R7, R9
        sb_on = 1'b1;
        wr(A_RELOAD, 16'd3, c);
        rd(A_RELOAD, v); chk("R6 accepted", v, 3);
        wr(A_CTRL, 16'h0033, c);
        exp_q.push_back('{c + 10, "R2 div2"});
        exp_q.push_back('{c + 18, "R5 reload period"});
        chk("R7 low after enable", int'(write_ok), 0);
        wr(A_RELOAD, 16'd9, c);
        rd(A_RELOAD, v); chk("R6 ignored", v, 3);
        wait_flag();
        chk("R9 irq on", int'(wake_irq), 1);
        wr(A_STATUS, 16'h0001, c);
        chk("R8 clear", int'(wake_flag), 0);
        wait_flag();
        wr(A_CTRL, 16'h0032, c);
        chk("R7 low edge0", int'(write_ok), 0);
        @(negedge clk); chk("R7 low edge1", int'(write_ok), 0);
        @(negedge clk); chk("R7 high edge2", int'(write_ok), 1);
        wr(A_STATUS, 16'h0001, c);

        // divide by 16, reload 1, irq off: R2, R8, R9
        wr(A_RELOAD, 16'd1, c);
        wr(A_CTRL, 16'h0001, c);
        exp_q.push_back('{c + 34, "R2 div16"});
        wait_flag();
        chk("R9 irq masked", int'(wake_irq), 0);
        wr(A_STATUS, 16'h0000, c);
        chk("R8 zero write", int'(wake_flag), 1);
        stop_timer(16'h0001);

        // divide by 8 reload 2, divide by 4 reload 0
        wr(A_RELOAD, 16'd2, c);
        wr(A_CTRL, 16'h0011, c);
        exp_q.push_back('{c + 26, "R2 div8"});
        wait_flag();
        stop_timer(16'h0011);
        wr(A_RELOAD, 16'd0, c);
        wr(A_CTRL, 16'h0021, c);
        exp_q.push_back('{c + 6, "R2 div4"});
        wait_flag();
        stop_timer(16'h0021);

        // R8 set and clear at the same edge (div2, reload 0: sets at c+4, c+6, ...)
        sb_on = 1'b0;
        wr(A_CTRL, 16'h0031, c);
        while (cyc != c + 5) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_STATUS; wr_data = 16'h0001;
        @(negedge clk);
        chk("R8 set wins", int'(wake_flag), 1);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 clear alone", int'(wake_flag), 0);
        stop_timer(16'h0031);

        // R3 strobe source 4, reload 2
        wr(A_RELOAD, 16'd2, c);
        wr(A_CTRL, 16'h0041, c);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk("R3 two strobes", int'(wake_flag), 0);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk("R3 third strobe", int'(wake_flag), 1);
        stop_timer(16'h0041);

        // R3 source 5 with strobe held high, reload 5
        sb_on = 1'b1;
        sec_tick = 1'b1;
        wr(A_RELOAD, 16'd5, c);
        wr(A_CTRL, 16'h0051, c);
        exp_q.push_back('{c + 8, "R3 source5"});
        wait_flag();
        stop_timer(16'h0051);

        // R4 source 7 extended range, reload 2
        wr(A_RELOAD, 16'd2, c);
        wr(A_CTRL, 16'h0071, c);
        exp_q.push_back('{c + 2 + 65539, "R4 extended"});
        wait_flag();
        stop_timer(16'h0071);
        sec_tick = 1'b0;

        chk("R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule